// File: doc/BRIEF.md
# Parity-Steered Dual Write-Back Buffer

Two decoder engines each produce one result symbol per cycle. Those symbols must be written back into a single-port store that is split into an even-address segment and an odd-address segment. Each segment can take one write per cycle, but both results of a cycle may target the same segment. This block absorbs that imbalance. Each segment has a small write FIFO that can accept up to two symbols per cycle, and each FIFO drains one write per cycle into its segment.

The write side does not compute addresses or parities of its own. Each engine writes results in the order in which it read its operands. The block therefore delays the read-side stream by a fixed latency of `LAT` cycles. That stream carries a valid bit, a 2-bit parity code and two segment rows, one per engine. The delayed copy tells the block which engine result goes to which FIFO and at which row. If a FIFO cannot hold what is offered, a sticky error flag is raised.

Top module: `wbk_dual_writeback`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, both write enables and the error flag are low. The error flag stays low until an overflow occurs.
- R2: A read issued in cycle t, with `rd_valid` high, captures `res1` and `res2` in cycle t+LAT. The first resulting segment write appears two cycles after that capture cycle.
- R3: Code 2'b00 means both engines target even rows. The engine-1 symbol is written to the even segment first, and the engine-2 symbol is written in the following cycle.
- R4: Code 2'b11 means both engines target odd rows. The engine-1 symbol is written to the odd segment first, and the engine-2 symbol is written in the following cycle.
- R5: Code 2'b01 sends engine 1 to the even segment and engine 2 to the odd segment. Both writes occur in the same cycle.
- R6: Code 2'b10 sends engine 1 to the odd segment and engine 2 to the even segment. Both writes occur in the same cycle.
- R7: Each segment receives at most one write per cycle. A backlog in a FIFO drains in consecutive cycles with no gaps.
- R8: Each write carries the row that was supplied with the same engine's read, together with that engine's result symbol. Writes to a segment keep arrival order.
- R9: A symbol that finds its FIFO full is dropped, and `ovf_err` rises. Symbols already accepted are still written. `ovf_err` stays high until reset.
- R10: Result inputs in a cycle that does not correspond to a valid read are ignored and produce no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | A pair of reads is issued this cycle |
| rd_code | input | 2 | Parity code of the pair: bit 1 is engine-1 parity, bit 0 is engine-2 parity (1 = odd) |
| rd_row1 | input | ROW_W | Segment row read by engine 1 |
| rd_row2 | input | ROW_W | Segment row read by engine 2 |
| res1 | input | DATA_W | Engine-1 result symbol |
| res2 | input | DATA_W | Engine-2 result symbol |
| even_we | output | 1 | Write strobe for the even segment |
| even_row | output | ROW_W | Row written in the even segment |
| even_data | output | DATA_W | Symbol written in the even segment |
| odd_we | output | 1 | Write strobe for the odd segment |
| odd_row | output | ROW_W | Row written in the odd segment |
| odd_data | output | DATA_W | Symbol written in the odd segment |
| ovf_err | output | 1 | Sticky overflow flag |

## Verification
The hardest state to reach is a FIFO that is exactly full while another pair arrives. That state only builds up when traffic is sustained and one-sided, so the stimulus streams code 00 for several consecutive cycles. A run of seven pairs fills the even FIFO to exactly its depth with no overflow. A run of twelve pairs forces drops from the eighth pair onward, and the number of surviving writes is counted against the two-in, one-out arithmetic. Exact write cycles are also checked for single pairs of each code, because the delayed steering and the registered drain each add latency.

// File: rtl/wbk_pkg.sv
package wbk_pkg;
  // Parity code carried with each read pair: bit 1 = engine 1, bit 0 = engine 2, 1 = odd
  typedef enum logic [1:0] {
    PAIR_EVEN = 2'b00,
    SPLIT_E1  = 2'b01,
    SPLIT_O1  = 2'b10,
    PAIR_ODD  = 2'b11
  } pair_code_e;

  localparam int SEG_EVEN = 0;
  localparam int SEG_ODD  = 1;
endpackage

// File: rtl/wbk_delay_line.sv
module wbk_delay_line #(
  parameter int W   = 8,
  parameter int LAT = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LAT; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < LAT; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[LAT-1];
endmodule

// File: rtl/wbk_steer.sv
module wbk_steer
  import wbk_pkg::*;
#(
  parameter int EW = 17
) (
  input  logic                valid,
  input  logic [1:0]          code,
  input  logic [EW-1:0]       ent1,
  input  logic [EW-1:0]       ent2,
  output logic [1:0][1:0]     seg_n,
  output logic [1:0][EW-1:0]  seg_s0,
  output logic [1:0][EW-1:0]  seg_s1
);
  always_comb begin
    seg_n  = '0;
    seg_s0 = {ent1, ent1};
    seg_s1 = {ent2, ent2};
    if (valid) begin
      case (pair_code_e'(code))
        PAIR_EVEN: seg_n[SEG_EVEN] = 2'd2;
        PAIR_ODD:  seg_n[SEG_ODD]  = 2'd2;
        SPLIT_E1: begin
          seg_n[SEG_EVEN]  = 2'd1;
          seg_n[SEG_ODD]   = 2'd1;
          seg_s0[SEG_ODD]  = ent2;
        end
        SPLIT_O1: begin
          seg_n[SEG_EVEN]  = 2'd1;
          seg_n[SEG_ODD]   = 2'd1;
          seg_s0[SEG_EVEN] = ent2;
        end
        default: seg_n = '0;
      endcase
    end
  end
endmodule

// File: rtl/wbk_seg_fifo.sv
module wbk_seg_fifo #(
  parameter int EW    = 17,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    push_n,
  input  logic [EW-1:0] slot0,
  input  logic [EW-1:0] slot1,
  output logic          out_we,
  output logic [EW-1:0] out_ent,
  output logic          ovf
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] cnt;
  logic          pop, acc0, acc1;
  logic [CW:0]   space;

  always_comb begin
    pop   = (cnt != '0);
    space = (CW+1)'(DEPTH) - {1'b0, cnt} + (CW+1)'(pop);
    acc0  = (push_n != 2'd0) && (space != '0);
    acc1  = (push_n == 2'd2) && (space >= (CW+1)'(2));
    ovf   = (CW+1)'(push_n) > space;
  end

  always_ff @(posedge clk) begin
    if (acc0) mem[tail] <= slot0;
    if (acc1) mem[tail + PW'(1)] <= slot1;
  end

  always_ff @(posedge clk) begin
    if (pop) out_ent <= mem[head];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head   <= '0;
      tail   <= '0;
      cnt    <= '0;
      out_we <= 1'b0;
    end else begin
      head   <= head + PW'(pop);
      tail   <= tail + PW'(acc0) + PW'(acc1);
      cnt    <= cnt + CW'(acc0) + CW'(acc1) - CW'(pop);
      out_we <= pop;
    end
  end
endmodule

// File: rtl/wbk_dual_writeback.sv
module wbk_dual_writeback
  import wbk_pkg::*;
#(
  parameter int ROW_W  = 9,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int LAT    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_valid,
  input  logic [1:0]        rd_code,
  input  logic [ROW_W-1:0]  rd_row1,
  input  logic [ROW_W-1:0]  rd_row2,
  input  logic [DATA_W-1:0] res1,
  input  logic [DATA_W-1:0] res2,
  output logic              even_we,
  output logic [ROW_W-1:0]  even_row,
  output logic [DATA_W-1:0] even_data,
  output logic              odd_we,
  output logic [ROW_W-1:0]  odd_row,
  output logic [DATA_W-1:0] odd_data,
  output logic              ovf_err
);
  localparam int EW  = ROW_W + DATA_W;
  localparam int DLW = 3 + 2 * ROW_W;

  logic [DLW-1:0]       dl_out;
  logic                 d_valid;
  logic [1:0]           d_code;
  logic [ROW_W-1:0]     d_row1, d_row2;
  logic [1:0][1:0]      seg_n;
  logic [1:0][EW-1:0]   seg_s0, seg_s1, seg_ent;
  logic [1:0]           seg_we, seg_ovf;

  wbk_delay_line #(.W(DLW), .LAT(LAT)) u_dly (
    .clk (clk),
    .rst (rst),
    .din ({rd_valid, rd_code, rd_row1, rd_row2}),
    .dout(dl_out)
  );

  assign {d_valid, d_code, d_row1, d_row2} = dl_out;

  wbk_steer #(.EW(EW)) u_steer (
    .valid (d_valid),
    .code  (d_code),
    .ent1  ({d_row1, res1}),
    .ent2  ({d_row2, res2}),
    .seg_n (seg_n),
    .seg_s0(seg_s0),
    .seg_s1(seg_s1)
  );

  for (genvar g = 0; g < 2; g++) begin : g_seg
    wbk_seg_fifo #(.EW(EW), .DEPTH(DEPTH)) u_fifo (
      .clk    (clk),
      .rst    (rst),
      .push_n (seg_n[g]),
      .slot0  (seg_s0[g]),
      .slot1  (seg_s1[g]),
      .out_we (seg_we[g]),
      .out_ent(seg_ent[g]),
      .ovf    (seg_ovf[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)           ovf_err <= 1'b0;
    else if (|seg_ovf) ovf_err <= 1'b1;
  end

  assign even_we   = seg_we[SEG_EVEN];
  assign even_row  = seg_ent[SEG_EVEN][EW-1:DATA_W];
  assign even_data = seg_ent[SEG_EVEN][DATA_W-1:0];
  assign odd_we    = seg_we[SEG_ODD];
  assign odd_row   = seg_ent[SEG_ODD][EW-1:DATA_W];
  assign odd_data  = seg_ent[SEG_ODD][DATA_W-1:0];
endmodule

// File: rtl/wbk_dual_writeback_chk.sv
module wbk_dual_writeback_chk #(
  parameter int LAT = 4
) (
  input logic clk,
  input logic rst,
  input logic rd_valid,
  input logic even_we,
  input logic odd_we,
  input logic ovf_err
);
  logic [LAT-1:0] vsh;
  logic           dv;
  int unsigned    pcnt, wcnt;

  assign dv = vsh[LAT-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      vsh  <= '0;
      pcnt <= 0;
      wcnt <= 0;
    end else begin
      vsh  <= {vsh[LAT-2:0], rd_valid};
      pcnt <= pcnt + (dv ? 2 : 0);
      wcnt <= wcnt + 32'(even_we) + 32'(odd_we);
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!even_we && !odd_we && !ovf_err));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf_err |=> ovf_err);

  a_r9_err_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_err) |-> $past(dv));

  a_r2_no_excess_writes: assert property (@(posedge clk) disable iff (rst)
    !ovf_err |-> (wcnt <= pcnt));

  a_r10_no_phantom_write: assert property (@(posedge clk) disable iff (rst)
    (pcnt == wcnt) |-> (!even_we && !odd_we));
endmodule

bind wbk_dual_writeback wbk_dual_writeback_chk #(.LAT(LAT)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .rd_valid(rd_valid),
  .even_we (even_we),
  .odd_we  (odd_we),
  .ovf_err (ovf_err)
);

// File: tb/wbk_dual_writeback_tb.sv
module wbk_dual_writeback_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W  = 9;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 8;
  localparam int LAT    = 4;
  localparam int EW     = ROW_W + DATA_W;

  logic clk = 1'b0, rst = 1'b1, rd_valid = 1'b0;
  logic [1:0] rd_code = '0;
  logic [ROW_W-1:0] rd_row1 = '0, rd_row2 = '0;
  logic [DATA_W-1:0] res1 = '0, res2 = '0;
  logic even_we, odd_we, ovf_err;
  logic [ROW_W-1:0] even_row, odd_row;
  logic [DATA_W-1:0] even_data, odd_data;

  wbk_dual_writeback #(.ROW_W(ROW_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .LAT(LAT)) u_dut (
    .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_code(rd_code),
    .rd_row1(rd_row1), .rd_row2(rd_row2), .res1(res1), .res2(res2),
    .even_we(even_we), .even_row(even_row), .even_data(even_data),
    .odd_we(odd_we), .odd_row(odd_row), .odd_data(odd_data), .ovf_err(ovf_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0, n_fail = 0;
  int n_even = 0, n_odd = 0, first_even = -1, last_even = -1, first_odd = -1, last_odd = -1;
  int drive_cyc = 0;
  bit sb_on = 1'b1;
  logic [EW-1:0] q_even[$], q_odd[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic sb(input bit seg, input logic [EW-1:0] got);
    logic [EW-1:0] e;
    if (seg ? (q_odd.size() == 0) : (q_even.size() == 0)) begin
      chk(1'b0, "R10", seg ? "unexpected odd write" : "unexpected even write", int'(got), 0);
    end else begin
      e = seg ? q_odd.pop_front() : q_even.pop_front();
      chk(got == e, "R8", seg ? "odd row/data" : "even row/data", int'(got), int'(e));
    end
  endtask

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (!rst) begin
      if (even_we) begin
        n_even++; if (first_even < 0) first_even = cyc; last_even = cyc;
        if (sb_on) sb(1'b0, {even_row, even_data});
      end
      if (odd_we) begin
        n_odd++; if (first_odd < 0) first_odd = cyc; last_odd = cyc;
        if (sb_on) sb(1'b1, {odd_row, odd_data});
      end
    end
  end

  function automatic logic [1:0] code_of(input int mode, input int i);
    return (mode < 4) ? 2'(mode) : 2'(i * 3 + 1);
  endfunction
  function automatic logic [ROW_W-1:0] row_of(input int i, input int eng, input int seed);
    return ROW_W'(i * 37 + seed + eng * 101);
  endfunction
  function automatic logic [DATA_W-1:0] dat_of(input int i, input int eng, input int seed);
    return DATA_W'(i * 29 + seed + eng * 71 + 5);
  endfunction

  task automatic clear_rec();
    n_even = 0; n_odd = 0; first_even = -1; last_even = -1; first_odd = -1; last_odd = -1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; rd_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    q_even.delete(); q_odd.delete(); sb_on = 1'b1;
  endtask

  task automatic run_stream(input int n, input int mode, input int seed, input bit push_exp);
    fork
      begin
        for (int i = 0; i < n; i++) begin
          @(negedge clk);
          rd_valid = 1'b1; rd_code = code_of(mode, i);
          rd_row1 = row_of(i, 0, seed); rd_row2 = row_of(i, 1, seed);
        end
        @(negedge clk); rd_valid = 1'b0; rd_code = '0;
      end
      begin
        @(negedge clk);
        repeat (LAT) @(negedge clk);
        for (int i = 0; i < n; i++) begin
          logic [1:0] c;
          if (i > 0) @(negedge clk);
          if (i == 0) drive_cyc = cyc;
          c = code_of(mode, i);
          res1 = dat_of(i, 0, seed); res2 = dat_of(i, 1, seed);
          if (push_exp) begin
            if (c[1]) q_odd.push_back({row_of(i, 0, seed), res1});
            else      q_even.push_back({row_of(i, 0, seed), res1});
            if (c[0]) q_odd.push_back({row_of(i, 1, seed), res2});
            else      q_even.push_back({row_of(i, 1, seed), res2});
          end
        end
        @(negedge clk); res1 = 8'hC3; res2 = 8'h3C;
      end
    join
    repeat (2 * DEPTH + LAT + 4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(even_we == 1'b0, "R1", "even_we after reset", int'(even_we), 0);
    chk(odd_we == 1'b0, "R1", "odd_we after reset", int'(odd_we), 0);
    chk(ovf_err == 1'b0, "R1", "ovf_err after reset", int'(ovf_err), 0);
  endtask

  task automatic t_single_pair(input int code, input string tag);
    int ec;
    clear_rec();
    run_stream(1, code, 17 + code * 5, 1'b1);
    ec = (code == 0) ? 2 : (code == 3) ? 0 : 1;
    chk(n_even == ec, tag, "even write count", n_even, ec);
    chk(n_odd == 2 - ec, tag, "odd write count", n_odd, 2 - ec);
    if (ec > 0) chk(first_even == drive_cyc + 2, "R2", "first even write cycle", first_even, drive_cyc + 2);
    if (ec < 2) chk(first_odd == drive_cyc + 2, "R2", "first odd write cycle", first_odd, drive_cyc + 2);
    if (ec == 2) chk(last_even == drive_cyc + 3, tag, "second even write cycle", last_even, drive_cyc + 3);
    if (ec == 0) chk(last_odd == drive_cyc + 3, tag, "second odd write cycle", last_odd, drive_cyc + 3);
    if (ec == 1) chk(first_even == first_odd, tag, "split writes same cycle", first_even, first_odd);
    chk(q_even.size() + q_odd.size() == 0, "R8", "all symbols written", q_even.size() + q_odd.size(), 0);
  endtask

  task automatic t_backlog();
    clear_rec();
    run_stream(4, 0, 91, 1'b1);
    chk(n_even == 8, "R7", "backlog even writes", n_even, 8);
    chk(last_even - first_even == 7, "R7", "backlog drains without gaps", last_even - first_even, 7);
    chk(n_odd == 0, "R7", "no odd writes", n_odd, 0);
  endtask

  task automatic t_mixed();
    clear_rec();
    run_stream(10, 4, 203, 1'b1);
    chk(n_even + n_odd == 20, "R8", "mixed total writes", n_even + n_odd, 20);
    chk(q_even.size() + q_odd.size() == 0, "R8", "mixed queues drained", q_even.size() + q_odd.size(), 0);
  endtask

  task automatic t_idle_results();
    clear_rec();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); res1 = DATA_W'(i * 11 + 1); res2 = DATA_W'(i * 5 + 2);
    end
    repeat (LAT + 4) @(negedge clk);
    chk(n_even + n_odd == 0, "R10", "writes without reads", n_even + n_odd, 0);
  endtask

  task automatic t_overflow();
    clear_rec();
    run_stream(7, 0, 55, 1'b1);
    chk(n_even == 14, "R9", "exactly full: writes", n_even, 14);
    chk(ovf_err == 1'b0, "R9", "exactly full: no error", int'(ovf_err), 0);
    clear_rec();
    sb_on = 1'b0;
    run_stream(12, 0, 77, 1'b0);
    chk(n_even == 19, "R9", "surviving writes after drops", n_even, 19);
    chk(n_odd == 0, "R9", "no odd writes", n_odd, 0);
    chk(ovf_err == 1'b1, "R9", "error raised and held", int'(ovf_err), 1);
    do_reset();
    chk(ovf_err == 1'b0, "R1", "error cleared by reset", int'(ovf_err), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_single_pair(0, "R3");
    t_single_pair(3, "R4");
    t_single_pair(1, "R5");
    t_single_pair(2, "R6");
    t_backlog();
    t_mixed();
    t_idle_results();
    t_overflow();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule